// File: doc/BRIEF.md
# Printer Port Register Block

This block holds the registers of a classic PC printer port as seen from a small 8-bit I/O bus. Three registers sit at consecutive byte addresses above a base fixed by parameter: an output data byte, a read-only status byte and a control byte. The bus side offers a 10-bit address, an address-enable qualifier, active-high read and write strobes and separate write and read data buses. The port side drives eight data lines with an output enable, four control lines and an interrupt request, and it samples five status lines.

A read returns the levels on the lines, not the stored bytes. This allows two checks. First, software can confirm what actually reached the connector. Second, with the direction bit set, the data lines become inputs that an external device drives.

Top module: `lpt_regs`

## Requirements
- R1: The block is selected only when `io_addr` is BASE, BASE+1 or BASE+2 (BASE = 0x378 by default). On a read while selected, `io_rdata_oe` is 1. In every other case `io_rdata_oe` is 0 and `io_rdata` is 0x00. BASE+3 is never selected.
- R2: While `io_aen` is 1, reads and writes are ignored at every address. `io_rdata_oe` stays 0 and no register changes.
- R3: A write strobe at BASE+0 that is seen on a rising clock edge loads `io_wdata` into the data latch. `pd_out` shows the new value after that edge.
- R4: A read of BASE+0 returns `pd_in`, the present level of the eight data lines.
- R5: A read of BASE+1 returns a fixed pattern built from the status lines. Bits 2..0 read as 1. Bits 3..6 are `st_pins_i[0..3]` (error, select-in, paper-empty, acknowledge), unchanged. Bit 7 is the inverse of `st_pins_i[4]` (busy).
- R6: Control bits 3..0 drive `ctl_pins_o[3:0]` (strobe, auto-feed, init, select-out, LSB first). Bits 0, 1 and 3 are inverted, and bit 2 is not, so `ctl_pins_o = ctrl[3:0] ^ 4'b1011`.
- R7: A read of BASE+2 returns the written control bits 3..0, recovered from the pins, in bits 3..0. Bit 4 is the interrupt-enable bit. Bits 7..5 read as 1.
- R8: `irq_o` equals `st_pins_i[3]` (acknowledge) while control bit 4 is 1. It is 0 while control bit 4 is 0.
- R9: `pd_oe` is 0 while control bit 5 (direction) is 1, and 1 while it is 0.
- R10: While `rst_n` is low, the control latch and the data latch are cleared. This gives `ctl_pins_o = 4'b1011`, `pd_oe = 1`, `irq_o = 0` and `pd_out = 0x00`.
- R11: Writes to BASE+1 or BASE+3, or to any address outside the window, leave both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | I/O address |
| io_aen | input | 1 | Address enable; high marks a DMA cycle, which is ignored |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0x00 when not driven |
| io_rdata_oe | output | 1 | Read bus drive enable |
| pd_in | input | 8 | Level seen on the data lines |
| pd_out | output | 8 | Data latch output |
| pd_oe | output | 1 | Data line output enable |
| ctl_pins_o | output | 4 | Control line levels |
| st_pins_i | input | 5 | Status lines: error, select-in, paper-empty, acknowledge, busy |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every address with the address-enable low and then high. An off-by-one decode, a decode that ignores the upper bits, or one that still answers at BASE+3 would drive the read bus where it must stay quiet.

It sweeps all 64 control values with the acknowledge line both low and high, and all 32 status patterns. A wrong inversion mask would show up as a pin level or read-back bit that differs from the written bit. Interrupt gating that ignores the enable would raise the request with the enable clear.

With the direction bit set, it sweeps external data values. A design that reads the latch instead of the lines would return the stale latched byte.

It also writes to the read-only offset, to offset 3 and during address-enable cycles. A design that lets any of these through would corrupt a latch that the bench then reads back.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  // register offsets inside the four-byte window
  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_STAT = 2'd1,
    OFS_CTRL = 2'd2,
    OFS_NONE = 2'd3
  } lpt_ofs_e;

  localparam int CTL_W  = 6;
  localparam int ST_W   = 5;
  localparam int BIT_IEN = 4;
  localparam int BIT_DIR = 5;

  // control bits inverted between latch and connector
  localparam logic [3:0] CTL_PIN_INV = 4'b1011;

  // latch bits -> pin levels (the same mapping undoes itself)
  function automatic logic [3:0] ctl_pin_map(input logic [3:0] bits);
    return bits ^ CTL_PIN_INV;
  endfunction

  // status lines -> status byte
  function automatic logic [7:0] status_word(input logic [ST_W-1:0] st);
    logic [7:0] w;
    w      = 8'h07;
    w[6:3] = st[3:0];
    w[7]   = ~st[4];
    return w;
  endfunction

endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
  import lpt_pkg::*;
#(
  parameter int                ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE   = 10'h378
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_aen,
  input  logic              io_rd,
  input  logic              io_wr,
  output lpt_ofs_e          ofs,
  output logic              rd_ev,
  output logic              wr_data_ev,
  output logic              wr_ctl_ev
);

  logic upper_hit;
  logic hit;

  assign upper_hit  = (io_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
  assign ofs        = lpt_ofs_e'(io_addr[1:0]);
  assign hit        = !io_aen && upper_hit && (ofs != OFS_NONE);
  assign rd_ev      = hit && io_rd;
  assign wr_data_ev = hit && io_wr && (ofs == OFS_DATA);
  assign wr_ctl_ev  = hit && io_wr && (ofs == OFS_CTRL);

  // R2: a DMA cycle produces no event
  p_aen_no_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_aen |-> !(rd_ev || wr_data_ev || wr_ctl_ev));

  // R11: write events are mutually exclusive
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_data_ev, wr_ctl_ev}) <= 1);

endmodule

// File: rtl/lpt_latch.sv
module lpt_latch
  import lpt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_ev,
  input  logic              wr_ctl_ev,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [CTL_W-1:0]  ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_data_ev) begin
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl_ev) begin
      ctl_q <= wdata[CTL_W-1:0];
    end
  end

  // R3: data latch takes the written byte
  p_data_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ev |=> (data_q == $past(wdata)));

  // R11: without a data write the latch holds
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_ev |=> $stable(data_q));

  // R11: without a control write the latch holds
  p_ctl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl_ev |=> $stable(ctl_q));

endmodule

// File: rtl/lpt_readpath.sv
module lpt_readpath
  import lpt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lpt_ofs_e          ofs,
  input  logic              rd_ev,
  input  logic [DATA_W-1:0] pd_in,
  input  logic [ST_W-1:0]   st_pins,
  input  logic [3:0]        ctl_pins,
  input  logic              ien,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              irq
);

  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    ctl_word          = '1;
    ctl_word[BIT_IEN] = ien;
    ctl_word[3:0]     = ctl_pin_map(ctl_pins);
  end

  always_comb begin
    unique case (ofs)
      OFS_DATA: sel_word = pd_in;
      OFS_STAT: sel_word = DATA_W'(status_word(st_pins));
      OFS_CTRL: sel_word = ctl_word;
      default:  sel_word = '0;
    endcase
  end

  assign rdata_oe = rd_ev;
  assign rdata    = rd_ev ? sel_word : '0;
  assign irq      = ien && st_pins[3];

  // R1: undriven bus carries zero
  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  // R8: a request needs the acknowledge line high
  p_irq_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_pins[3]);

  // R5: the three low status bits read as ones
  p_stat_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && ofs == OFS_STAT) |-> (rdata[2:0] == 3'b111));

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int                ADDR_W = 10,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 10'h378
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_aen,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rdata_oe,
  input  logic [DATA_W-1:0] pd_in,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  output logic [3:0]        ctl_pins_o,
  input  logic [ST_W-1:0]   st_pins_i,
  output logic              irq_o
);

  lpt_ofs_e          ofs;
  logic              rd_ev;
  logic              wr_data_ev;
  logic              wr_ctl_ev;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] data_q;

  lpt_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_aen     (io_aen),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .ofs        (ofs),
    .rd_ev      (rd_ev),
    .wr_data_ev (wr_data_ev),
    .wr_ctl_ev  (wr_ctl_ev)
  );

  lpt_latch #(.DATA_W(DATA_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_ev (wr_data_ev),
    .wr_ctl_ev  (wr_ctl_ev),
    .wdata      (io_wdata),
    .data_q     (data_q),
    .ctl_q      (ctl_q)
  );

  assign pd_out     = data_q;
  assign pd_oe      = !ctl_q[BIT_DIR];
  assign ctl_pins_o = ctl_pin_map(ctl_q[3:0]);

  lpt_readpath #(.DATA_W(DATA_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .ofs      (ofs),
    .rd_ev    (rd_ev),
    .pd_in    (pd_in),
    .st_pins  (st_pins_i),
    .ctl_pins (ctl_pins_o),
    .ien      (ctl_q[BIT_IEN]),
    .rdata    (io_rdata),
    .rdata_oe (io_rdata_oe),
    .irq      (irq_o)
  );

  // R1: the read bus is driven only inside the three-byte window
  p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata_oe |-> (io_rd && (io_addr - BASE) < ADDR_W'(3)));

  // R6: pins follow the written control nibble with the inversion mask
  p_ctl_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl_ev |=> (ctl_pins_o == ($past(io_wdata[3:0]) ^ 4'b1011)));

  // R9: direction bit written high releases the data lines
  p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl_ev |=> (pd_oe == !$past(io_wdata[BIT_DIR])));

  // R8: interrupt enable written low silences the request
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl_ev && !io_wdata[BIT_IEN]) |=> !irq_o);

  // R10: right after reset the port is idle
  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |-> (ctl_pins_o == 4'b1011 && pd_oe && !irq_o));

endmodule

// File: tb/lpt_regs_tb_top.sv
module lpt_regs_tb_top;

  localparam int BASE = 'h378;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic       io_aen = 1'b0;
  logic       io_rd = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       io_rdata_oe;
  logic [7:0] pd_in;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic [3:0] ctl_pins_o;
  logic [4:0] st_pins_i = '0;
  logic       irq_o;
  logic [7:0] ext_d = '0;

  int n_vec  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // resolved line level: latch wins while enabled, else the outside driver
  assign pd_in = pd_oe ? pd_out : ext_d;

  lpt_regs dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_aen(io_aen),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rdata_oe(io_rdata_oe), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .ctl_pins_o(ctl_pins_o), .st_pins_i(st_pins_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d, input bit aen);
    @(negedge clk);
    io_addr = 10'(a); io_wdata = 8'(d); io_aen = aen; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_aen = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    io_addr = 10'(a); io_rd = 1'b1;
    #1;
    d = io_rdata; oe = io_rdata_oe;
    io_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    logic       oe;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check("R10 ctl pins", ctl_pins_o, 4'hB);
    check("R10 pd_oe", pd_oe, 1);
    st_pins_i = 5'b01000;
    #1;
    check("R10 irq", irq_o, 0);
    check("R10 pd_out", pd_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(BASE + 2, rd, oe);
    check("R7 ctl after reset", rd, 8'hE0);

    // R1 / R2: full address sweep, both qualifier states
    for (int aen = 0; aen < 2; aen++) begin
      for (int a = 0; a < 1024; a++) begin
        bit want;
        want = (aen == 0) && (a >= BASE) && (a <= BASE + 2);
        @(negedge clk);
        io_addr = 10'(a); io_aen = aen[0]; io_rd = 1'b1;
        #1;
        check(aen ? "R2 oe with aen" : "R1 oe decode", io_rdata_oe, want);
        if (!want) check("R1 quiet bus", io_rdata, 0);
        io_rd = 1'b0; io_aen = 1'b0;
      end
    end

    // R3 / R4: every data value, written and read back through the lines
    for (int v = 0; v < 256; v++) begin
      bus_write(BASE, v, 1'b0);
      check("R3 pd_out", pd_out, v);
      bus_read(BASE, rd, oe);
      check("R4 read data", rd, v);
    end

    // R6 / R7 / R8 / R9: every control value, acknowledge low and high
    for (int v = 0; v < 64; v++) begin
      bus_write(BASE + 2, v, 1'b0);
      check("R6 ctl pins", ctl_pins_o, (v & 15) ^ 11);
      check("R9 pd_oe", pd_oe, ((v >> 5) & 1) ^ 1);
      bus_read(BASE + 2, rd, oe);
      check("R7 ctl read", rd, 8'hE0 | (v & 31));
      for (int ack = 0; ack < 2; ack++) begin
        st_pins_i = 5'(ack << 3);
        #1;
        check("R8 irq", irq_o, ((v >> 4) & 1) & ack);
      end
    end

    // R5: all status patterns
    for (int s = 0; s < 32; s++) begin
      st_pins_i = 5'(s);
      bus_read(BASE + 1, rd, oe);
      check("R5 status", rd, (7 + (s % 16) * 8 + (s < 16 ? 128 : 0)));
    end

    // R4 / R9: lines released, outside values visible
    bus_write(BASE, 8'h3C, 1'b0);
    bus_write(BASE + 2, 8'h20, 1'b0);
    check("R9 released", pd_oe, 0);
    for (int v = 0; v < 256; v++) begin
      ext_d = 8'(v);
      bus_read(BASE, rd, oe);
      check("R4 external data", rd, v);
    end
    bus_write(BASE + 2, 8'h00, 1'b0);
    bus_read(BASE, rd, oe);
    check("R4 latch back on lines", rd, 8'h3C);

    // R11 / R2: writes that must not land
    bus_write(BASE, 8'hA5, 1'b0);
    bus_write(BASE + 2, 8'h15, 1'b0);
    bus_write(BASE + 1, 8'h5A, 1'b0);
    bus_write(BASE + 3, 8'h2A, 1'b0);
    bus_write(BASE, 8'h00, 1'b1);
    bus_write(BASE + 2, 8'h0A, 1'b1);
    bus_write('h278, 8'h77, 1'b0);
    bus_write('h27A, 8'h2F, 1'b0);
    bus_read(BASE, rd, oe);
    check("R11 data kept", rd, 8'hA5);
    bus_read(BASE + 2, rd, oe);
    check("R11 ctl kept", rd, 8'hF5);
    check("R2 ctl pins kept", ctl_pins_o, 4'h5 ^ 4'hB);

    // R10: reset mid-run clears both latches
    bus_write(BASE + 2, 8'h3F, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 pins on reset", ctl_pins_o, 4'hB);
    check("R10 oe on reset", pd_oe, 1);
    check("R10 data on reset", pd_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(BASE + 2, rd, oe);
    check("R10 ctl read after reset", rd, 8'hE0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all) act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule